// File: doc/BRIEF.md
# Serial Management Frame Engine

This block turns a single host request into one complete management frame on the two-wire PHY management bus. It then returns the 16-bit result. The management bus has a clock, an output data line with its own output-enable, and an input data line. The host gives a PHY address, a register number, a read/write flag and, for writes, 16 bits of data. The engine drives the whole frame without further help from the host: preamble, start and opcode fields, both address fields, turnaround, data and one trailing idle clock. It then parks the bus.

The request side is a valid/ready handshake. `req_ready` is high only while the engine is idle. A request transfers on a clock edge where both `req_valid` and `req_ready` are high. While a frame is in flight, `req_ready` stays low and any `req_valid` is ignored. The host holds the request fields stable only in the transfer cycle. The response side applies no back-pressure. `done` pulses for one cycle and `rd_data` is valid in that cycle. `rd_data` keeps its value until the next request is accepted.

The management clock is built from the system clock. Its low phase lasts `LOW_CYCLES` system clocks and its high phase lasts `HIGH_CYCLES` system clocks. The defaults of 20 and 20 give 2.5 MHz from a 100 MHz system clock.

Top module: `mdio_frame_engine`

## Requirements
- R1: After reset, `mdc`, `mdio_o` and `mdio_oe` are low, `done` is low and `req_ready` is high.
- R2: A request is taken only when `req_ready` is high, and `req_ready` is low from the transfer edge until the frame ends. A `req_valid` pulse during a frame changes neither the frame in flight nor the bus after it; no second frame starts.
- R3: Every frame opens with 32 bit times of data 1, with the output enabled.
- R4: Bit times 32 to 45 are driven with the output enabled. They carry the start code 0,1, then the opcode (read = 1,0; write = 0,1), then the 5-bit PHY address and then the 5-bit register number, each address most significant bit first.
- R5: A write frame has 65 bit times. Bit times 46 and 47 are a turnaround with the output disabled. Bit times 48 to 63 carry the write data, most significant bit first, with the output enabled. Bit time 64 is an extra clock with the output disabled.
- R6: A read frame has 64 bit times. The output is disabled from bit time 46 to the end. The input bits of bit times 47 to 62 form `rd_data`, most significant bit first.
- R7: Each bit time is `LOW_CYCLES` system clocks with `mdc` low, followed by `HIGH_CYCLES` system clocks with `mdc` high. Output data and enable change only at the start of a bit time. The first rising edge of `mdc` comes `LOW_CYCLES` clocks after the transfer edge.
- R8: `mdio_i` is sampled once per input bit, in the last system clock of the high phase.
- R9: `done` rises `frame_bits × (LOW_CYCLES + HIGH_CYCLES)` clocks after the transfer edge and lasts one cycle. In that cycle `mdc`, `mdio_o` and `mdio_oe` are low and `req_ready` is high. After a write, `rd_data` is zero.
- R10: Whenever `mdio_oe` is low, `mdio_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request can transfer |
| req_write | input | 1 | 1 = write frame, 0 = read frame |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register number |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-cycle frame completion pulse |
| rd_data | output | 16 | Read result, valid with `done` |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Output enable for `mdio_o` |
| mdio_i | input | 1 | Management data in |

## Verification
The PHY model in the bench drives each read bit only from the falling management clock edge. In one read it presents the correct bit only in the last high-phase cycle and the inverted bit in every other cycle. An engine that samples early, late or on the wrong bit window returns a corrupted word. Writes with all-ones and all-zeros data at the extreme addresses expose a misplaced field, a wrong opcode or a missing second turnaround bit. A wrong frame length shows up as a wrong rising-edge count or a shifted `done` cycle. A request pulse injected in the middle of a frame catches an engine that restarts or queues a frame while busy.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam logic [1:0] MF_START    = 2'b01;
  localparam logic [1:0] MF_OP_READ  = 2'b10;
  localparam logic [1:0] MF_OP_WRITE = 2'b01;

  typedef enum logic {
    ENG_IDLE = 1'b0,
    ENG_RUN  = 1'b1
  } eng_state_e;
endpackage

// File: rtl/mdio_bit_timer.sv
module mdio_bit_timer #(
  parameter int LOW_CYCLES  = 20,
  parameter int HIGH_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic mdc,
  output logic bit_end
);
  localparam int MAX_C = (LOW_CYCLES > HIGH_CYCLES) ? LOW_CYCLES : HIGH_CYCLES;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] LOW_LAST  = CNT_W'(LOW_CYCLES - 1);
  localparam logic [CNT_W-1:0] HIGH_LAST = CNT_W'(HIGH_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic             hi;

  assign mdc     = hi;
  assign bit_end = run && hi && (cnt == HIGH_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      hi  <= 1'b0;
    end else if (start || !run) begin
      cnt <= '0;
      hi  <= 1'b0;
    end else if (!hi) begin
      if (cnt == LOW_LAST) begin
        hi  <= 1'b1;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      if (cnt == HIGH_LAST) begin
        hi  <= 1'b0;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter #(
  parameter int FRAME_W = 65,
  parameter int IDX_W   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_data,
  input  logic [FRAME_W-1:0] load_oe,
  input  logic [IDX_W-1:0]   load_last,
  input  logic               advance,
  input  logic               clear,
  output logic               ser_data,
  output logic               ser_oe,
  output logic [IDX_W-1:0]   idx,
  output logic               last_bit
);
  logic [FRAME_W-1:0] data_sr;
  logic [FRAME_W-1:0] oe_sr;
  logic [IDX_W-1:0]   last_idx;

  assign ser_data = data_sr[FRAME_W-1];
  assign ser_oe   = oe_sr[FRAME_W-1];
  assign last_bit = (idx == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_sr  <= '0;
      oe_sr    <= '0;
      idx      <= '0;
      last_idx <= '0;
    end else if (load) begin
      data_sr  <= load_data;
      oe_sr    <= load_oe;
      idx      <= '0;
      last_idx <= load_last;
    end else if (clear) begin
      data_sr  <= '0;
      oe_sr    <= '0;
      idx      <= '0;
    end else if (advance) begin
      data_sr  <= {data_sr[FRAME_W-2:0], 1'b0};
      oe_sr    <= {oe_sr[FRAME_W-2:0], 1'b0};
      idx      <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_rd_capture.sv
module mdio_rd_capture #(
  parameter int DATA_BITS = 16,
  parameter int IDX_W     = 7,
  parameter int FIRST     = 47
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 enable,
  input  logic                 strobe,
  input  logic [IDX_W-1:0]     idx,
  input  logic                 sdi,
  output logic [DATA_BITS-1:0] data
);
  localparam logic [IDX_W-1:0] WIN_LO = IDX_W'(FIRST);
  localparam logic [IDX_W-1:0] WIN_HI = IDX_W'(FIRST + DATA_BITS);

  logic in_window;
  assign in_window = (idx >= WIN_LO) && (idx < WIN_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
    end else if (clear) begin
      data <= '0;
    end else if (enable && strobe && in_window) begin
      data <= {data[DATA_BITS-2:0], sdi};
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int LOW_CYCLES    = 20,
  parameter int HIGH_CYCLES   = 20,
  parameter int PREAMBLE_BITS = 32,
  parameter int ADDR_BITS     = 5,
  parameter int DATA_BITS     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_BITS-1:0] req_phy,
  input  logic [ADDR_BITS-1:0] req_reg,
  input  logic [DATA_BITS-1:0] req_wdata,
  output logic                 done,
  output logic [DATA_BITS-1:0] rd_data,
  output logic                 mdc,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  input  logic                 mdio_i
);
  localparam int HDR_BITS  = PREAMBLE_BITS + 4 + 2 * ADDR_BITS;
  localparam int WR_BITS   = HDR_BITS + 2 + DATA_BITS + 1;
  localparam int RD_BITS   = HDR_BITS + 1 + DATA_BITS + 1;
  localparam int FRAME_W   = WR_BITS;
  localparam int TAIL_BITS = FRAME_W - HDR_BITS;
  localparam int IDX_W     = $clog2(FRAME_W + 1);
  localparam int CAP_FIRST = HDR_BITS + 1;

  eng_state_e state;
  logic       is_read;
  logic       accept;
  logic       bit_end;
  logic       last_bit;
  logic       finish;
  logic [IDX_W-1:0]   bit_idx;
  logic [FRAME_W-1:0] frame_data;
  logic [FRAME_W-1:0] frame_oe;
  logic [IDX_W-1:0]   frame_last;

  assign req_ready = (state == ENG_IDLE);
  assign accept    = req_valid && req_ready;
  assign finish    = bit_end && last_bit;

  // Frame image: bit time 0 sits at the MSB and leaves first.
  always_comb begin
    if (req_write) begin
      frame_data = {{PREAMBLE_BITS{1'b1}}, MF_START, MF_OP_WRITE, req_phy, req_reg,
                    2'b00, req_wdata, 1'b0};
      frame_oe   = {{HDR_BITS{1'b1}}, 2'b00, {DATA_BITS{1'b1}}, 1'b0};
      frame_last = IDX_W'(WR_BITS - 1);
    end else begin
      frame_data = {{PREAMBLE_BITS{1'b1}}, MF_START, MF_OP_READ, req_phy, req_reg,
                    {TAIL_BITS{1'b0}}};
      frame_oe   = {{HDR_BITS{1'b1}}, {TAIL_BITS{1'b0}}};
      frame_last = IDX_W'(RD_BITS - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ENG_IDLE;
      is_read <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= finish;
      if (accept) begin
        state   <= ENG_RUN;
        is_read <= !req_write;
      end else if (finish) begin
        state   <= ENG_IDLE;
      end
    end
  end

  mdio_bit_timer #(
    .LOW_CYCLES (LOW_CYCLES),
    .HIGH_CYCLES(HIGH_CYCLES)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept),
    .run    (state == ENG_RUN),
    .mdc    (mdc),
    .bit_end(bit_end)
  );

  mdio_frame_shifter #(
    .FRAME_W(FRAME_W),
    .IDX_W  (IDX_W)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_data(frame_data),
    .load_oe  (frame_oe),
    .load_last(frame_last),
    .advance  (bit_end && !last_bit),
    .clear    (finish),
    .ser_data (mdio_o),
    .ser_oe   (mdio_oe),
    .idx      (bit_idx),
    .last_bit (last_bit)
  );

  mdio_rd_capture #(
    .DATA_BITS(DATA_BITS),
    .IDX_W    (IDX_W),
    .FIRST    (CAP_FIRST)
  ) u_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (accept),
    .enable(is_read),
    .strobe(bit_end),
    .idx   (bit_idx),
    .sdi   (mdio_i),
    .data  (rd_data)
  );
endmodule

// File: rtl/mdio_frame_engine_chk.sv
module mdio_frame_engine_chk #(
  parameter int HIGH_CYCLES = 20
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic done,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe
);
  logic [15:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_run <= '0;
    else        hi_run <= mdc ? hi_run + 1'b1 : '0;
  end

  AST_STABLE_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R7
  AST_HIGH_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> (int'(hi_run) < HIGH_CYCLES)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_PARKED_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mdc && !mdio_o && !mdio_oe && req_ready)); // R9
  AST_READY_FALLS_ON_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_ready) |-> $past(req_valid)); // R2
  AST_BUSY_WHILE_CLOCKING: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> !req_ready); // R2
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !mdio_oe |-> !mdio_o); // R10
endmodule

bind mdio_frame_engine mdio_frame_engine_chk #(.HIGH_CYCLES(HIGH_CYCLES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .done     (done),
  .mdc      (mdc),
  .mdio_o   (mdio_o),
  .mdio_oe  (mdio_oe)
);

// File: tb/mdio_frame_engine_bench.sv
module mdio_frame_engine_bench;
  localparam int LOWC = 20;
  localparam int HIGHC = 20;
  localparam int PER = LOWC + HIGHC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_write = 1'b0;
  logic [4:0] req_phy = '0;
  logic [4:0] req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic done;
  logic [15:0] rd_data;
  logic mdc, mdio_o, mdio_oe;
  logic mdio_i = 1'b1;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  mdio_frame_engine #(.LOW_CYCLES(LOWC), .HIGH_CYCLES(HIGHC)) u_mdio_frame_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .done(done), .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Expected bit stream, index i = bit time i.
  task automatic build_exp(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] wd, output logic [64:0] ed,
                           output logic [64:0] eo, output int n);
    ed = '0; eo = '0;
    n = wr ? 65 : 64;
    for (int i = 0; i < n; i++) begin
      if (i < 32) begin ed[i] = 1'b1; eo[i] = 1'b1; end
      else if (i == 32) begin ed[i] = 1'b0; eo[i] = 1'b1; end
      else if (i == 33) begin ed[i] = 1'b1; eo[i] = 1'b1; end
      else if (i == 34) begin ed[i] = !wr; eo[i] = 1'b1; end
      else if (i == 35) begin ed[i] = wr; eo[i] = 1'b1; end
      else if (i <= 40) begin ed[i] = phy[40 - i]; eo[i] = 1'b1; end
      else if (i <= 45) begin ed[i] = rg[45 - i]; eo[i] = 1'b1; end
      else if (wr && i >= 48 && i <= 63) begin ed[i] = wd[63 - i]; eo[i] = 1'b1; end
    end
  endtask

  // narrow: correct input bit only in last high cycle, inverted elsewhere (R8)
  task automatic run_txn(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] wd, input logic [15:0] reply,
                         input bit narrow, input bit poke);
    logic [64:0] ed, eo, gd, go;
    int n, rises, falls, c, jb, ph, quiet_bad;
    bit timing_ok, seen_done, prev, idle_ok;
    logic [15:0] got_rd;
    build_exp(wr, phy, rg, wd, ed, eo, n);
    gd = '0; go = '0; rises = 0; falls = 0; quiet_bad = 0;
    timing_ok = 1'b1; seen_done = 1'b0; prev = 1'b0; idle_ok = 1'b0; got_rd = 'x;
    @(negedge clk);
    chk(req_ready === 1'b1, "R2", "ready when idle", {31'b0, req_ready}, 32'd1);
    req_valid = 1'b1; req_write = wr; req_phy = phy; req_reg = rg; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_write = !wr; req_phy = ~phy; req_reg = ~rg; req_wdata = ~wd;
    c = 1;
    while (!seen_done && c < 4000) begin
      if (poke && c == 300) begin
        chk(req_ready === 1'b0, "R2", "ready low mid-frame", {31'b0, req_ready}, 32'd0);
        req_valid = 1'b1;
      end
      if (poke && c == 301) req_valid = 1'b0;
      if (!mdio_oe && mdio_o) quiet_bad++;
      if (mdc && !prev) begin
        if (rises < 65) begin gd[rises] = mdio_o; go[rises] = mdio_oe; end
        if (c != LOWC + 1 + rises * PER) timing_ok = 1'b0;
        rises++;
      end
      if (!mdc && prev) begin
        falls++;
        if (!narrow) mdio_i = (falls >= 47 && falls <= 62) ? reply[62 - falls] : 1'b1;
      end
      if (narrow && c >= LOWC + 1) begin
        jb = (c - LOWC - 1) / PER;
        ph = (c - LOWC - 1) % PER;
        if (jb >= 47 && jb <= 62)
          mdio_i = (ph == HIGHC - 1) ? reply[62 - jb] : ~reply[62 - jb];
        else
          mdio_i = 1'b1;
      end
      if (done) begin
        seen_done = 1'b1;
        got_rd = rd_data;
        idle_ok = !mdc && !mdio_o && !mdio_oe && req_ready;
        chk(c == n * PER + 1, "R9", "done cycle", c, n * PER + 1);
      end
      prev = mdc;
      if (!seen_done) begin @(negedge clk); c++; end
    end
    mdio_i = 1'b1;
    chk(seen_done, "R9", "done seen", {31'b0, seen_done}, 32'd1);
    chk(idle_ok, "R9", "bus parked at done", {31'b0, idle_ok}, 32'd1);
    chk(timing_ok, "R7", "rising edge timing", {31'b0, timing_ok}, 32'd1);
    chk(rises == n, wr ? "R5" : "R6", "bit time count", rises, n);
    chk(gd[31:0] === ed[31:0] && go[31:0] === eo[31:0], "R3", "preamble", gd[31:0], ed[31:0]);
    chk(gd[45:32] === ed[45:32] && go[45:32] === eo[45:32], "R4", "start/op/addr fields",
        {18'b0, gd[45:32]}, {18'b0, ed[45:32]});
    chk(gd[64:46] === ed[64:46] && go[64:46] === eo[64:46], wr ? "R5" : "R6", "tail fields",
        {gd[64:49], go[64:49]}, {ed[64:49], eo[64:49]});
    chk(quiet_bad == 0, "R10", "data low while disabled", quiet_bad, 0);
    if (wr) chk(got_rd === 16'h0, "R9", "rd_data after write", {16'b0, got_rd}, 32'd0);
    else chk(got_rd === reply, narrow ? "R8" : "R6", "read data", {16'b0, got_rd}, {16'b0, reply});
    @(negedge clk);
    chk(done === 1'b0, "R9", "done one cycle", {31'b0, done}, 32'd0);
    if (poke) begin
      repeat (LOWC + 5) @(negedge clk);
      chk(mdc === 1'b0 && req_ready === 1'b1, "R2", "no frame from ignored request",
          {30'b0, mdc, req_ready}, 32'd1);
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_1234);
    repeat (3) @(negedge clk);
    chk(mdc === 1'b0 && mdio_o === 1'b0 && mdio_oe === 1'b0, "R1", "bus in reset",
        {29'b0, mdc, mdio_o, mdio_oe}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready === 1'b1 && done === 1'b0 && mdc === 1'b0, "R1", "idle after reset",
        {29'b0, req_ready, done, mdc}, 32'd4);
    // directed corners
    run_txn(1'b1, 5'd31, 5'd0, 16'hFFFF, 16'h0, 1'b0, 1'b0);
    run_txn(1'b1, 5'd0, 5'd31, 16'h0000, 16'h0, 1'b0, 1'b0);
    run_txn(1'b0, 5'd21, 5'd10, 16'h0, 16'h8001, 1'b0, 1'b0);
    run_txn(1'b0, 5'd31, 5'd31, 16'h0, 16'h0000, 1'b0, 1'b0);
    run_txn(1'b0, 5'd3, 5'd17, 16'h0, 16'hA5C3, 1'b1, 1'b0);
    run_txn(1'b1, 5'd9, 5'd4, 16'h1234, 16'h0, 1'b0, 1'b1);
    run_txn(1'b0, 5'd12, 5'd6, 16'h0, 16'h7E81, 1'b0, 1'b1);
    // constrained random
    for (int k = 0; k < 18; k++) begin
      bit wr;
      wr = 1'($urandom % 2);
      run_txn(wr, 5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom),
              (k % 6) == 5 && !wr, 1'b0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule